// File: doc/BRIEF.md
# Vsync-Latched Shadow Register Bank

This block keeps two copies of the configuration registers for two display windows and for a small group of frame-wide settings. Software writes the working copy through a simple register port. The display pipeline sees only the active copy. The active copy changes only on a vertical sync strobe, so the pipeline never sees a half-written configuration in the middle of a frame.

Each window has its own protect bit. At every vsync, each window whose protect bit is clear loads its whole active set from its working set. A protected window keeps its active values as they are. This lets software change several registers of one window and then release them all together.

The frame-wide group is loaded only when software has requested it. Writing the update request bit arms a small two-state machine. In `UPD_IDLE` no request is pending. `UPD_IDLE -> UPD_ARMED` on a request write. In `UPD_ARMED`, a vsync loads the frame group. That vsync then moves the machine `UPD_ARMED -> UPD_IDLE`, unless a new request arrives in the same cycle, in which case it stays in `UPD_ARMED`. A soft reset forces either state to `UPD_IDLE`. A soft-reset write clears both copies, the protect bits and the pending request at one clock edge.

Top module: `vsync_shadow_bank`

## Requirements
- R1: After reset, every working and active register, the protect bits and the update request read as zero, and `win_active` and `glob_active` are all zero.
- R2: A write to a window register (word address 8 + 4*window + index, index 0 = control, 1 = base, 2 = size, 3 = position) shows up in the working copy on the next cycle. The active copy is unchanged until a vsync.
- R3: On a vsync, every window whose protect bit is clear loads its whole active set from the working values held before that edge.
- R4: While a window's protect bit is set, a vsync leaves its active set unchanged. After the bit is cleared, the next vsync loads the pending values.
- R5: The protect register (address 1) holds one bit per window, with bit w for window w. Each bit holds back only its own window.
- R6: Clearing bit 0 (enable) of a window control register leaves the active enable at 1 until the next vsync. After that vsync it reads 0.
- R7: Writing 1 to bit 0 of the control register (address 0) sets the update request. The bit reads 1 until a vsync services it, and then reads 0. Writing 0 to it has no effect.
- R8: The frame group (addresses 2 and 3) loads its active copy only on a vsync while an update request is pending. A vsync with no pending request leaves that active copy unchanged.
- R9: A vsync uses the values held before its edge. A request written in the same cycle as a vsync is not serviced by that vsync and is still pending for the next one. A register write in the same cycle as a vsync is not loaded by that vsync.
- R10: Writing 1 to bit 1 of the control register is a soft reset. At that edge it clears both copies, all protect bits and the pending request. It suppresses a request written in the same word, and the bit itself reads 0.
- R11: With `rd_active` set, a read of a shadowed address returns the active copy; otherwise it returns the working copy. Unmapped addresses read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Register write word address |
| wr_data | input | DW | Register write data |
| rd_addr | input | ADDR_W | Register read word address (combinational read) |
| rd_active | input | 1 | Read the active copy instead of the working copy |
| rd_data | output | DW | Register read data |
| vsync | input | 1 | One-cycle vertical sync strobe |
| win_active | output | NUM_WIN*REGS_PER_WIN*DW | Active window registers; window w, index r at bit (w*REGS_PER_WIN + r)*DW |
| glob_active | output | NGLOB*DW | Active frame-group registers; index r at bit r*DW |

## Verification
The hardest case to reach from the ports is a collision at one edge: a vsync that coincides with a new update request, or with a write to a shadowed register. Here the edge must act on the pre-edge values and leave the new ones for the following frame. The stimulus drives `wr_en` and `vsync` in the same cycle. It then reads back the request bit and both copies before and after one more vsync. Protect behaviour is exercised the same way. The protect bit is set, the working copy is changed, and a vsync is given. The active copy is read while the working copy differs, then again after the bit is released.

// File: rtl/shadow_bank_pkg.sv
package shadow_bank_pkg;

    typedef enum logic [0:0] {
        UPD_IDLE  = 1'b0,
        UPD_ARMED = 1'b1
    } upd_state_e;

    localparam int unsigned CTRL_REQ_BIT  = 0;
    localparam int unsigned CTRL_SRST_BIT = 1;

endpackage

// File: rtl/shadow_group.sv
module shadow_group #(
    parameter int unsigned NREG = 4,
    parameter int unsigned DW   = 32,
    localparam int unsigned IDX_W = (NREG > 1) ? $clog2(NREG) : 1,
    localparam int unsigned FLAT  = NREG * DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [DW-1:0]    wr_data,
    input  logic             load,
    output logic [FLAT-1:0]  work_flat,
    output logic [FLAT-1:0]  act_flat
);

    for (genvar r = 0; r < NREG; r++) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                work_flat[r*DW +: DW] <= '0;
                act_flat[r*DW +: DW]  <= '0;
            end else if (clr) begin
                work_flat[r*DW +: DW] <= '0;
                act_flat[r*DW +: DW]  <= '0;
            end else begin
                if (load)
                    act_flat[r*DW +: DW] <= work_flat[r*DW +: DW];
                if (wr_en && (wr_idx == IDX_W'(r)))
                    work_flat[r*DW +: DW] <= wr_data;
            end
        end
    end

endmodule

// File: rtl/upd_fsm.sv
module upd_fsm
    import shadow_bank_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic req,
    input  logic vsync,
    output logic pending,
    output logic service
);

    upd_state_e state, nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= UPD_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        if (clr) begin
            nxt = UPD_IDLE;
        end else begin
            unique case (state)
                UPD_IDLE:  if (req) nxt = UPD_ARMED;
                UPD_ARMED: if (vsync && !req) nxt = UPD_IDLE;
                default:   nxt = UPD_IDLE;
            endcase
        end
    end

    always_comb begin
        pending = (state == UPD_ARMED);
        service = (state == UPD_ARMED) && vsync && !clr;
    end

    // R7: a serviced request with no new one drops; an unserviced one stays
    p_pending_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && vsync && !req && !clr) |=> !pending);
    p_pending_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !vsync && !clr) |=> pending);
    // R9: a request arriving with the vsync survives it
    p_req_survives_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !clr) |=> pending);

endmodule

// File: rtl/vsync_shadow_bank.sv
module vsync_shadow_bank
    import shadow_bank_pkg::*;
#(
    parameter int unsigned NUM_WIN      = 2,
    parameter int unsigned REGS_PER_WIN = 4,
    parameter int unsigned NGLOB        = 2,
    parameter int unsigned DW           = 32,
    parameter int unsigned ADDR_W       = 6
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [DW-1:0]                     wr_data,
    input  logic [ADDR_W-1:0]                 rd_addr,
    input  logic                              rd_active,
    output logic [DW-1:0]                     rd_data,
    input  logic                              vsync,
    output logic [NUM_WIN*REGS_PER_WIN*DW-1:0] win_active,
    output logic [NGLOB*DW-1:0]               glob_active
);

    localparam int unsigned RIDX_W = (REGS_PER_WIN > 1) ? $clog2(REGS_PER_WIN) : 1;
    localparam int unsigned GIDX_W = (NGLOB > 1) ? $clog2(NGLOB) : 1;
    localparam int unsigned WIN_W  = (NUM_WIN > 1) ? $clog2(NUM_WIN) : 1;
    localparam int unsigned WFLAT  = REGS_PER_WIN * DW;
    localparam int unsigned GFLAT  = NGLOB * DW;
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] A_PROT   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] A_GLOB   = ADDR_W'(2);
    localparam logic [ADDR_W-1:0] A_GEND   = ADDR_W'(2 + NGLOB);
    localparam logic [ADDR_W-1:0] WIN_BASE = ADDR_W'(8);

    logic [NUM_WIN-1:0] protect;
    logic               srst, req, pending, service;
    logic [WFLAT-1:0]   win_work [NUM_WIN];
    logic [WFLAT-1:0]   win_act  [NUM_WIN];
    logic [GFLAT-1:0]   glob_work, glob_act;

    // write decode
    logic               w_ctrl, w_prot, w_glob, w_win;
    logic [ADDR_W-1:0]  w_wofs;
    logic [ADDR_W-RIDX_W-1:0] w_wsel;
    logic [RIDX_W-1:0]  w_ridx;
    logic [WIN_W-1:0]   w_widx;
    logic [GIDX_W-1:0]  w_gidx;

    always_comb begin
        w_ctrl = wr_en && (wr_addr == A_CTRL);
        w_prot = wr_en && (wr_addr == A_PROT);
        w_glob = wr_en && (wr_addr >= A_GLOB) && (wr_addr < A_GEND);
        w_gidx = GIDX_W'(wr_addr - A_GLOB);
        w_wofs = ADDR_W'(wr_addr - WIN_BASE);
        w_ridx = w_wofs[RIDX_W-1:0];
        w_wsel = w_wofs[ADDR_W-1:RIDX_W];
        w_widx = w_wsel[WIN_W-1:0];
        w_win  = wr_en && (wr_addr >= WIN_BASE) && (int'(w_wsel) < NUM_WIN);
        srst   = w_ctrl && wr_data[CTRL_SRST_BIT];
        req    = w_ctrl && wr_data[CTRL_REQ_BIT] && !srst;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      protect <= '0;
        else if (srst)   protect <= '0;
        else if (w_prot) protect <= wr_data[NUM_WIN-1:0];
    end

    upd_fsm u_upd (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (srst),
        .req     (req),
        .vsync   (vsync),
        .pending (pending),
        .service (service)
    );

    shadow_group #(.NREG(NGLOB), .DW(DW)) u_glob (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (srst),
        .wr_en     (w_glob),
        .wr_idx    (w_gidx),
        .wr_data   (wr_data),
        .load      (service),
        .work_flat (glob_work),
        .act_flat  (glob_act)
    );
    assign glob_active = glob_act;

    for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
        shadow_group #(.NREG(REGS_PER_WIN), .DW(DW)) u_grp (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (srst),
            .wr_en     (w_win && (w_widx == WIN_W'(w))),
            .wr_idx    (w_ridx),
            .wr_data   (wr_data),
            .load      (vsync && !protect[w]),
            .work_flat (win_work[w]),
            .act_flat  (win_act[w])
        );
        assign win_active[w*WFLAT +: WFLAT] = win_act[w];

        // R3: unprotected window takes the pre-edge working set
        p_copy_unprot_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (vsync && !protect[w] && !srst) |=> (win_act[w] == $past(win_work[w])));
        // R4: protected window holds across vsync
        p_hold_prot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (vsync && protect[w] && !srst) |=> $stable(win_act[w]));
        // R2: no vsync, no change to the active set
        p_hold_novs_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!vsync && !srst) |=> $stable(win_act[w]));
    end

    // read decode
    logic [ADDR_W-1:0]  r_wofs;
    logic [ADDR_W-RIDX_W-1:0] r_wsel;
    logic [RIDX_W-1:0]  r_ridx;
    logic [WIN_W-1:0]   r_widx;
    logic [GIDX_W-1:0]  r_gidx;

    always_comb begin
        r_gidx = GIDX_W'(rd_addr - A_GLOB);
        r_wofs = ADDR_W'(rd_addr - WIN_BASE);
        r_ridx = r_wofs[RIDX_W-1:0];
        r_wsel = r_wofs[ADDR_W-1:RIDX_W];
        r_widx = r_wsel[WIN_W-1:0];
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[CTRL_REQ_BIT] = pending;
        end else if (rd_addr == A_PROT) begin
            rd_data[NUM_WIN-1:0] = protect;
        end else if ((rd_addr >= A_GLOB) && (rd_addr < A_GEND)) begin
            rd_data = rd_active ? glob_act[r_gidx*DW +: DW] : glob_work[r_gidx*DW +: DW];
        end else if ((rd_addr >= WIN_BASE) && (int'(r_wsel) < NUM_WIN)) begin
            rd_data = rd_active ? win_act[r_widx][r_ridx*DW +: DW]
                                : win_work[r_widx][r_ridx*DW +: DW];
        end
    end

    // R8: frame group moves only on a serviced vsync
    p_glob_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!(vsync && pending) && !srst) |=> $stable(glob_act));
    p_glob_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (vsync && pending && !srst) |=> (glob_act == $past(glob_work)));
    // R10: soft reset clears protect, request and frame group at once
    p_srst_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst |=> (protect == '0 && !pending && glob_act == '0));

endmodule

// File: tb/tb_vsync_shadow_bank.sv
module tb_vsync_shadow_bank;

    localparam int DW = 32;
    localparam int AW = 6;
    localparam int NV = 40;
    localparam logic [3:0] OP_WR = 4'd1, OP_VS = 4'd2, OP_RW = 4'd3, OP_RA = 4'd4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic          rd_active = 1'b0;
    logic [DW-1:0] rd_data;
    logic          vsync = 1'b0;
    logic [255:0]  win_active;
    logic [63:0]   glob_active;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    vsync_shadow_bank dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_active(rd_active),
        .rd_data(rd_data), .vsync(vsync), .win_active(win_active),
        .glob_active(glob_active)
    );

    // {op, requirement, address, data-or-expected}
    localparam logic [47:0] VEC [NV] = '{
        {OP_WR, 4'd2,  8'h08, 32'h0000_0001}, // R2 win0 enable
        {OP_RW, 4'd2,  8'h08, 32'h0000_0001}, // R2 working updated
        {OP_RA, 4'd2,  8'h08, 32'h0000_0000}, // R2 active not yet
        {OP_WR, 4'd3,  8'h09, 32'h1000_0000}, // R3
        {OP_WR, 4'd3,  8'h0C, 32'h0000_0003}, // R3 win1 control
        {OP_VS, 4'd3,  8'h00, 32'h0},
        {OP_RA, 4'd3,  8'h08, 32'h0000_0001}, // R3
        {OP_RA, 4'd3,  8'h09, 32'h1000_0000}, // R3
        {OP_RA, 4'd3,  8'h0C, 32'h0000_0003}, // R3
        {OP_WR, 4'd5,  8'h01, 32'h0000_0002}, // R5 protect win1
        {OP_WR, 4'd4,  8'h0C, 32'h0000_0005}, // R4
        {OP_WR, 4'd6,  8'h08, 32'h0000_0000}, // R6 clear enable
        {OP_RA, 4'd6,  8'h08, 32'h0000_0001}, // R6 still enabled
        {OP_VS, 4'd6,  8'h00, 32'h0},
        {OP_RA, 4'd6,  8'h08, 32'h0000_0000}, // R6 now off
        {OP_RA, 4'd4,  8'h0C, 32'h0000_0003}, // R4 held, R11 active differs
        {OP_WR, 4'd4,  8'h01, 32'h0000_0000}, // R4 release
        {OP_RA, 4'd4,  8'h0C, 32'h0000_0003}, // R4 no vsync yet
        {OP_VS, 4'd4,  8'h00, 32'h0},
        {OP_RA, 4'd4,  8'h0C, 32'h0000_0005}, // R4 loaded
        {OP_WR, 4'd8,  8'h02, 32'h0000_0780}, // R8
        {OP_VS, 4'd8,  8'h00, 32'h0},
        {OP_RA, 4'd8,  8'h02, 32'h0000_0000}, // R8 no request
        {OP_WR, 4'd7,  8'h00, 32'h0000_0001}, // R7 request
        {OP_RW, 4'd7,  8'h00, 32'h0000_0001}, // R7 pending
        {OP_VS, 4'd7,  8'h00, 32'h0},
        {OP_RA, 4'd8,  8'h02, 32'h0000_0780}, // R8 serviced
        {OP_RW, 4'd7,  8'h00, 32'h0000_0000}, // R7 self-cleared
        {OP_WR, 4'd7,  8'h00, 32'h0000_0000}, // R7 write 0
        {OP_RW, 4'd7,  8'h00, 32'h0000_0000}, // R7 no effect
        {OP_RW, 4'd11, 8'h3F, 32'h0000_0000}, // R11 unmapped
        {OP_WR, 4'd5,  8'h01, 32'h0000_0001}, // R5 protect win0 only
        {OP_RW, 4'd5,  8'h01, 32'h0000_0001}, // R5
        {OP_WR, 4'd5,  8'h0A, 32'h0000_00AA}, // R5
        {OP_WR, 4'd5,  8'h0E, 32'h0000_00BB}, // R5
        {OP_VS, 4'd5,  8'h00, 32'h0},
        {OP_RA, 4'd5,  8'h0A, 32'h0000_0000}, // R5 win0 held
        {OP_RA, 4'd5,  8'h0E, 32'h0000_00BB}, // R5 win1 loaded
        {OP_WR, 4'd5,  8'h01, 32'h0000_0000},
        {OP_RW, 4'd11, 8'h0C, 32'h0000_0005}  // R11 working read
    };

    task automatic check(input int req, input logic [255:0] act, input logic [255:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL R%0d actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d, input logic vs);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d; vsync = vs;
        @(negedge clk);
        wr_en = 1'b0; vsync = 1'b0;
    endtask

    task automatic do_vsync();
        @(negedge clk);
        vsync = 1'b1;
        @(negedge clk);
        vsync = 1'b0;
    endtask

    task automatic do_read(input int req, input logic [AW-1:0] a, input logic act,
                           input logic [DW-1:0] exp);
        @(negedge clk);
        rd_addr = a; rd_active = act;
        #1;
        check(req, 256'(rd_data), 256'(exp));
    endtask

    initial begin
        #(200000 * 5);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        @(negedge clk);
        check(1, win_active, '0);
        check(1, 256'(glob_active), '0);
        do_read(1, 6'h00, 1'b0, 32'h0);
        do_read(1, 6'h01, 1'b0, 32'h0);
        do_read(1, 6'h08, 1'b0, 32'h0);
        do_read(1, 6'h0C, 1'b1, 32'h0);

        for (int i = 0; i < NV; i++) begin
            case (VEC[i][47:44])
                OP_WR:   do_write(VEC[i][37:32], VEC[i][31:0], 1'b0);
                OP_VS:   do_vsync();
                OP_RW:   do_read(int'(VEC[i][43:40]), VEC[i][37:32], 1'b0, VEC[i][31:0]);
                default: do_read(int'(VEC[i][43:40]), VEC[i][37:32], 1'b1, VEC[i][31:0]);
            endcase
        end
        // R6 at the port: win0 enable bit is 0
        @(negedge clk);
        check(6, 256'(win_active[0]), 256'(0));

        // R9 collisions with vsync
        do_write(6'h03, 32'h0000_0055, 1'b0);
        do_write(6'h00, 32'h0000_0001, 1'b1);   // request with vsync
        do_read(9, 6'h00, 1'b0, 32'h1);
        do_read(9, 6'h03, 1'b1, 32'h0);
        do_write(6'h0F, 32'h0000_0077, 1'b1);   // window write with vsync
        do_read(9, 6'h03, 1'b1, 32'h55);
        do_read(9, 6'h00, 1'b0, 32'h0);
        do_read(9, 6'h0F, 1'b1, 32'h0);
        do_vsync();
        do_read(9, 6'h0F, 1'b1, 32'h77);

        // R10 soft reset
        do_write(6'h01, 32'h0000_0003, 1'b0);
        do_write(6'h00, 32'h0000_0001, 1'b0);
        do_write(6'h00, 32'h0000_0003, 1'b0);
        do_read(10, 6'h01, 1'b0, 32'h0);
        do_read(10, 6'h00, 1'b0, 32'h0);
        do_read(10, 6'h08, 1'b0, 32'h0);
        do_read(10, 6'h0C, 1'b0, 32'h0);
        check(10, win_active, '0);
        check(10, 256'(glob_active), '0);
        do_write(6'h02, 32'h0000_0099, 1'b0);
        do_vsync();
        do_read(10, 6'h02, 1'b1, 32'h0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule